// File: doc/BRIEF.md
# Fail-safe system clock switcher

This block decides which of five clock sources drives the system clock and does the switch through a command and status handshake. Software writes a source code into the command register. A busy flag, which reads as "not ready", stays high until the status output reports the new source. A request is only carried out after the target source reports that it is both active and ready. A request that waits too long is dropped, and the clock stays as it was.

Two monitors run in the clock domain of the internal 4 MHz RC. One watches a toggling beat from the external oscillator and declares it stopped when no edge arrives within a programmable number of cycles. The other watches the PLL lock indication. A stop or an unlock of the source that drives the system forces the select code to the internal 4 MHz RC and raises a sticky flag. If the oscillator had been the system clock, its restart switches the system back to it. Each flag paired with an enable raises an interrupt.

All configuration writes, including command writes and flag clears, are ignored unless the protection unlock input is high.

Top module: `clk_failsafe_sw`

## Requirements
- R1: After reset, `sys_sel` and `sys_stat` are 4 (48 MHz RC), and `sw_busy`, `flags`, `irq`, `pll_on_rc`, `osc_freq` and `osc_bypass` are all 0.
- R2: The source codes are 1 = 4 MHz RC, 2 = low-speed RC, 3 = external oscillator, 4 = 48 MHz RC and 5 = PLL. Bit i of `src_act`/`src_rdy` belongs to code i+1. Writing a valid code to address 0 raises `sw_busy`. `sw_busy` stays high until `sys_stat` equals the new code.
- R3: A switch completes only while the target shows both active and ready. If it has not completed after SW_WAIT cycles, the request is dropped: `sw_busy` clears and `sys_stat` keeps its old value.
- R4: Command codes 0, 6 and 7 are ignored: `sw_busy` stays low and the selection does not change.
- R5: While `cfg_unlock` is low, every register write is ignored.
- R6: When the oscillator monitor is enabled (address 1, bit 0), stop flag `flags[0]` is set if no beat edge is seen for the programmed timeout. If the selection is 3 or 5 at that moment, it becomes 1.
- R7: When the monitored oscillator shows edges again after being stopped (or is seen for the first time), start flag `flags[1]` is set. If the last fallback came from code 3 and no command was written since, the selection returns to 3.
- R8: When the PLL monitor is enabled (address 1, bit 1) and lock drops, unlock flag `flags[2]` is set. If the selection is 5, it becomes 1 and `pll_on_rc` goes high. `pll_on_rc` stays high until a later switch completes.
- R9: Writing 1 to a bit at address 2 clears that flag. Writing 0 leaves it.
- R10: `irq` is high exactly when some flag i is set together with its enable at address 1, bit 2+i.
- R11: Address 3 takes the oscillator frequency code (MHz/4 − 1) in bits 2:0 and a filter-bypass bit in bit 3. Codes above 5 reject the whole write. Codes 3 to 5 force the bypass bit on.
- R12: With a monitor disabled, its source can stop or unlock without setting a flag or changing the selection.
- R13: Address 4 holds the stop timeout in 4 MHz cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 4 MHz RC domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_unlock | input | 1 | Write protection open |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| src_act | input | 5 | Per-source active indication |
| src_rdy | input | 5 | Per-source ready indication |
| osc_beat | input | 1 | Toggling beat from the external oscillator |
| pll_lock | input | 1 | PLL lock indication |
| sys_sel | output | 3 | Source code driven to the clock mux |
| sys_stat | output | 3 | Source code reported as in use |
| sw_busy | output | 1 | Switch in progress (ready-low) |
| pll_on_rc | output | 1 | RC has replaced the PLL after an unlock |
| flags | output | 3 | Sticky stop, start and unlock flags |
| irq | output | 1 | Interrupt request |
| osc_freq | output | 3 | Oscillator frequency code |
| osc_bypass | output | 1 | Oscillator filter bypass enable |

## Verification
The bench sweeps all eight command codes and all sixteen frequency/bypass writes, and computes the expected register state arithmetically.

- A design that accepted codes 0, 6 or 7 would leave `sw_busy` high or select an unknown source.
- A design that skipped the bypass rule would leave the bypass off above 12 MHz.
- A design that switched before both active and ready were seen, or never gave up on a dead target, would be caught with `sw_busy` wrong or with the status changed.
- Two fallback cases are checked. A stop while the PLL runs must fall back without a later automatic return to the oscillator. A stop with the monitor disabled must change nothing. A design that confused the two would leave the system on the wrong source.

// File: rtl/csw_pkg.sv
package csw_pkg;
  localparam logic [2:0] SRC_RC4  = 3'd1;
  localparam logic [2:0] SRC_LRC  = 3'd2;
  localparam logic [2:0] SRC_OSC  = 3'd3;
  localparam logic [2:0] SRC_RC48 = 3'd4;
  localparam logic [2:0] SRC_PLL  = 3'd5;

  localparam logic [2:0] A_CMD  = 3'd0;
  localparam logic [2:0] A_MON  = 3'd1;
  localparam logic [2:0] A_FLAG = 3'd2;
  localparam logic [2:0] A_OSC  = 3'd3;
  localparam logic [2:0] A_TMO  = 3'd4;

  localparam int NSRC = 5;
  localparam int NFLG = 3;

  function automatic logic code_ok(input logic [2:0] c);
    return (c >= SRC_RC4) && (c <= SRC_PLL);
  endfunction

  function automatic logic pick_src(input logic [NSRC-1:0] v, input logic [2:0] c);
    logic r;
    case (c)
      3'd1: r = v[0];
      3'd2: r = v[1];
      3'd3: r = v[2];
      3'd4: r = v[3];
      3'd5: r = v[4];
      default: r = 1'b0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/csw_sync.sv
module csw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/csw_beatmon.sv
module csw_beatmon #(
  parameter int TW     = 8,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [TW-1:0] tmo,
  input  logic          beat,
  output logic          stop_p,
  output logic          start_p
);
  logic          beat_s, prev_q, edge_w;
  logic [TW-1:0] cnt_q, cnt_d;
  logic          alive_q, alive_d;

  csw_sync #(.STAGES(STAGES)) u_sync (.clk(clk), .rst_n(rst_n), .d(beat), .q(beat_s));

  assign edge_w  = beat_s ^ prev_q;
  assign stop_p  = en && !edge_w && alive_q && (cnt_q == tmo);
  assign start_p = en && edge_w && !alive_q;

  always_comb begin
    cnt_d   = cnt_q;
    alive_d = alive_q;
    if (!en) begin
      cnt_d   = '0;
      alive_d = 1'b0;
    end else if (edge_w) begin
      cnt_d   = '0;
      alive_d = 1'b1;
    end else if (cnt_q != tmo) begin
      cnt_d = cnt_q + 1'b1;
    end else begin
      alive_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      cnt_q   <= '0;
      alive_q <= 1'b0;
    end else begin
      prev_q  <= beat_s;
      cnt_q   <= cnt_d;
      alive_q <= alive_d;
    end
  end

  // R6
  stop_kills_alive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_p |=> !alive_q);
endmodule

// File: rtl/csw_lockmon.sv
module csw_lockmon #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic lock,
  output logic unlock_p
);
  logic lock_s, prev_q;

  csw_sync #(.STAGES(STAGES)) u_sync (.clk(clk), .rst_n(rst_n), .d(lock), .q(lock_s));

  assign unlock_p = en && prev_q && !lock_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lock_s;
  end
endmodule

// File: rtl/csw_regs.sv
module csw_regs
  import csw_pkg::*;
#(
  parameter int          DW      = 8,
  parameter int          TW      = 8,
  parameter logic [7:0]  DEF_TMO = 8'd64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            unlock,
  input  logic            wr_en,
  input  logic [2:0]      wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [NFLG-1:0] flag_set,
  output logic            cmd_valid,
  output logic [2:0]      cmd_code,
  output logic [1:0]      mon_en,
  output logic [TW-1:0]   tmo,
  output logic [NFLG-1:0] flags,
  output logic            irq,
  output logic [2:0]      osc_freq,
  output logic            osc_bypass
);
  logic            wr_ok;
  logic [1:0]      en_q, en_d;
  logic [NFLG-1:0] ie_q, ie_d, flg_q, flg_d, clr_v;
  logic [TW-1:0]   tmo_q, tmo_d;
  logic [2:0]      frq_q, frq_d;
  logic            byp_q, byp_d;
  logic [2:0]      new_frq;

  assign wr_ok     = wr_en && unlock;
  assign cmd_code  = wr_data[2:0];
  assign cmd_valid = wr_ok && (wr_addr == A_CMD) && code_ok(wr_data[2:0]);
  assign new_frq   = wr_data[2:0];
  assign clr_v     = (wr_ok && wr_addr == A_FLAG) ? wr_data[NFLG-1:0] : '0;

  always_comb begin
    en_d  = en_q;
    ie_d  = ie_q;
    tmo_d = tmo_q;
    frq_d = frq_q;
    byp_d = byp_q;
    flg_d = (flg_q & ~clr_v) | flag_set;
    if (wr_ok) begin
      case (wr_addr)
        A_MON: begin
          en_d = wr_data[1:0];
          ie_d = wr_data[2+:NFLG];
        end
        A_OSC: begin
          if (new_frq <= 3'd5) begin
            frq_d = new_frq;
            byp_d = wr_data[3] | (new_frq >= 3'd3);
          end
        end
        A_TMO:   tmo_d = wr_data[TW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      ie_q  <= '0;
      flg_q <= '0;
      tmo_q <= DEF_TMO[TW-1:0];
      frq_q <= '0;
      byp_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      ie_q  <= ie_d;
      flg_q <= flg_d;
      tmo_q <= tmo_d;
      frq_q <= frq_d;
      byp_q <= byp_d;
    end
  end

  assign mon_en     = en_q;
  assign tmo        = tmo_q;
  assign flags      = flg_q;
  assign irq        = |(flg_q & ie_q);
  assign osc_freq   = frq_q;
  assign osc_bypass = byp_q;

  // R5
  locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !unlock |=> ($stable(en_q) && $stable(ie_q) && $stable(tmo_q) && $stable(frq_q) && $stable(byp_q)));
  // R9
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flg_q & $past(flg_q & ~clr_v)) == $past(flg_q & ~clr_v)));
  // R11
  bypass_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frq_q >= 3'd3) |-> byp_q);
endmodule

// File: rtl/csw_switch.sv
module csw_switch
  import csw_pkg::*;
#(
  parameter int SW_WAIT = 256
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [2:0]      cmd_code,
  input  logic [NSRC-1:0] src_ok,
  input  logic            osc_stop,
  input  logic            osc_start,
  input  logic            pll_unlock,
  output logic [2:0]      sel_o,
  output logic [2:0]      stat_o,
  output logic            busy_o,
  output logic            pll_rc_o
);
  localparam int WCW = $clog2(SW_WAIT + 1);
  localparam logic [WCW-1:0] WAIT_LAST = WCW'(SW_WAIT - 1);

  logic [2:0]     sel_q, sel_d, stat_q, tgt_q, tgt_d;
  logic           pend_q, pend_d, ret_q, ret_d, prc_q, prc_d;
  logic [WCW-1:0] wcnt_q, wcnt_d;
  logic           osc_fault, pll_fault, fault;

  assign osc_fault = osc_stop && (sel_q == SRC_OSC || sel_q == SRC_PLL);
  assign pll_fault = pll_unlock && (sel_q == SRC_PLL);
  assign fault     = osc_fault || pll_fault;

  always_comb begin
    sel_d  = sel_q;
    tgt_d  = tgt_q;
    pend_d = pend_q;
    ret_d  = ret_q;
    prc_d  = prc_q;
    wcnt_d = wcnt_q;
    if (fault) begin
      sel_d  = SRC_RC4;
      pend_d = 1'b0;
      ret_d  = osc_stop && (sel_q == SRC_OSC);
      if (sel_q == SRC_PLL) prc_d = 1'b1;
    end else if (osc_start && ret_q && !pend_q) begin
      sel_d = SRC_OSC;
      ret_d = 1'b0;
    end else if (cmd_valid) begin
      pend_d = 1'b1;
      tgt_d  = cmd_code;
      wcnt_d = '0;
      ret_d  = 1'b0;
    end else if (pend_q) begin
      if (pick_src(src_ok, tgt_q)) begin
        sel_d  = tgt_q;
        pend_d = 1'b0;
        prc_d  = 1'b0;
      end else if (wcnt_q == WAIT_LAST) begin
        pend_d = 1'b0;
      end else begin
        wcnt_d = wcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= SRC_RC48;
      stat_q <= SRC_RC48;
      tgt_q  <= SRC_RC48;
      pend_q <= 1'b0;
      ret_q  <= 1'b0;
      prc_q  <= 1'b0;
      wcnt_q <= '0;
    end else begin
      sel_q  <= sel_d;
      stat_q <= sel_q;
      tgt_q  <= tgt_d;
      pend_q <= pend_d;
      ret_q  <= ret_d;
      prc_q  <= prc_d;
      wcnt_q <= wcnt_d;
    end
  end

  assign sel_o    = sel_q;
  assign stat_o   = stat_q;
  assign busy_o   = pend_q || (stat_q != sel_q);
  assign pll_rc_o = prc_q;

  // R3
  honour_ready_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pend_q) && !$past(fault) && (sel_q != $past(sel_q))) |-> pick_src($past(src_ok), sel_q));
  // R6
  osc_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_stop && sel_q == SRC_OSC) |=> (sel_q == SRC_RC4));
  // R8
  pll_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_unlock && sel_q == SRC_PLL) |=> (sel_q == SRC_RC4 && prc_q));
endmodule

// File: rtl/clk_failsafe_sw.sv
module clk_failsafe_sw
  import csw_pkg::*;
#(
  parameter int         SW_WAIT = 256,
  parameter int         TW      = 8,
  parameter logic [7:0] DEF_TMO = 8'd64,
  parameter int         STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_unlock,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [4:0] src_act,
  input  logic [4:0] src_rdy,
  input  logic       osc_beat,
  input  logic       pll_lock,
  output logic [2:0] sys_sel,
  output logic [2:0] sys_stat,
  output logic       sw_busy,
  output logic       pll_on_rc,
  output logic [2:0] flags,
  output logic       irq,
  output logic [2:0] osc_freq,
  output logic       osc_bypass
);
  logic            rst_s_n;
  logic            cmd_valid;
  logic [2:0]      cmd_code;
  logic [1:0]      mon_en;
  logic [TW-1:0]   tmo;
  logic            osc_stop, osc_start, pll_unlock;
  logic [NFLG-1:0] flag_set;

  csw_sync #(.STAGES(2)) u_rst (.clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_s_n));

  assign flag_set = {pll_unlock, osc_start, osc_stop};

  csw_regs #(.DW(8), .TW(TW), .DEF_TMO(DEF_TMO)) u_regs (
    .clk(clk), .rst_n(rst_s_n), .unlock(cfg_unlock), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .flag_set(flag_set),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .mon_en(mon_en), .tmo(tmo),
    .flags(flags), .irq(irq), .osc_freq(osc_freq), .osc_bypass(osc_bypass)
  );

  csw_beatmon #(.TW(TW), .STAGES(STAGES)) u_oscmon (
    .clk(clk), .rst_n(rst_s_n), .en(mon_en[0]), .tmo(tmo), .beat(osc_beat),
    .stop_p(osc_stop), .start_p(osc_start)
  );

  csw_lockmon #(.STAGES(STAGES)) u_pllmon (
    .clk(clk), .rst_n(rst_s_n), .en(mon_en[1]), .lock(pll_lock), .unlock_p(pll_unlock)
  );

  csw_switch #(.SW_WAIT(SW_WAIT)) u_sw (
    .clk(clk), .rst_n(rst_s_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .src_ok(src_act & src_rdy), .osc_stop(osc_stop), .osc_start(osc_start),
    .pll_unlock(pll_unlock), .sel_o(sys_sel), .stat_o(sys_stat),
    .busy_o(sw_busy), .pll_rc_o(pll_on_rc)
  );

  // R12
  no_flag_when_off_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mon_en == 2'b00) |-> (flag_set == '0));
endmodule

// File: tb/tb_clk_failsafe_sw.sv
module tb_clk_failsafe_sw;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_unlock = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [4:0] src_act = '1;
  logic [4:0] src_rdy = '1;
  logic       osc_beat = 1'b0;
  logic       pll_lock = 1'b0;
  logic       beat_on = 1'b0;
  logic [2:0] sys_sel, sys_stat, flags, osc_freq;
  logic       sw_busy, pll_on_rc, irq, osc_bypass;

  int checks = 0;
  int errors = 0;

  clk_failsafe_sw #(.SW_WAIT(8)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_unlock(cfg_unlock), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .src_act(src_act), .src_rdy(src_rdy),
    .osc_beat(osc_beat), .pll_lock(pll_lock), .sys_sel(sys_sel), .sys_stat(sys_stat),
    .sw_busy(sw_busy), .pll_on_rc(pll_on_rc), .flags(flags), .irq(irq),
    .osc_freq(osc_freq), .osc_bypass(osc_bypass)
  );

  always #5 clk = ~clk;

  always begin
    @(negedge clk);
    if (beat_on) begin
      @(negedge clk);
      osc_beat = ~osc_beat;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_done();
    for (int i = 0; i < 40 && sw_busy; i++) @(negedge clk);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int prev;
    int pf, pb;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    // R1 reset state
    check("R1 sel", sys_sel, 4);
    check("R1 stat", sys_stat, 4);
    check("R1 busy", sw_busy, 0);
    check("R1 flags", flags, 0);
    check("R1 irq", irq, 0);
    check("R1 pll_on_rc", pll_on_rc, 0);
    check("R1 freq", osc_freq, 0);
    check("R1 bypass", osc_bypass, 0);

    // R2 / R4 sweep of all command codes
    prev = 4;
    for (int c = 0; c < 8; c++) begin
      wr(3'd0, 8'(c));
      check((c >= 1 && c <= 5) ? "R2 busy raised" : "R4 busy stays low",
            sw_busy, (c >= 1 && c <= 5) ? 1 : 0);
      wait_done();
      if (c >= 1 && c <= 5) prev = c;
      check("R2/R4 stat", sys_stat, prev);
      check("R2/R4 sel", sys_sel, prev);
    end

    // R3 target never ready: dropped after wait window
    wr(3'd0, 8'd4); wait_done();
    src_rdy[1] = 1'b0;
    wr(3'd0, 8'd2);
    check("R3 busy while waiting", sw_busy, 1);
    idle(15);
    check("R3 request dropped", sw_busy, 0);
    check("R3 stat unchanged", sys_stat, 4);
    // R3 active without ready is not enough, then ready arrives
    wr(3'd0, 8'd2);
    idle(3);
    check("R3 no switch on active only", sys_sel, 4);
    src_rdy[1] = 1'b1;
    wait_done();
    check("R3 switch after ready", sys_stat, 2);

    // R5 locked writes ignored
    cfg_unlock = 1'b0;
    wr(3'd0, 8'd1);
    check("R5 cmd ignored busy", sw_busy, 0);
    idle(3);
    check("R5 cmd ignored stat", sys_stat, 2);
    wr(3'd3, 8'd2);
    check("R5 freq ignored", osc_freq, 0);
    cfg_unlock = 1'b1;

    // R11 sweep of frequency code and bypass
    pf = 0; pb = 0;
    for (int k = 0; k < 16; k++) begin
      wr(3'd3, 8'(k));
      if ((k & 7) <= 5) begin
        pf = k & 7;
        pb = ((k >> 3) & 1) | ((pf >= 3) ? 1 : 0);
      end
      check("R11 freq", osc_freq, pf);
      check("R11 bypass", osc_bypass, pb);
    end

    // R13 timeout, R7 first start, R10 irq, R9 clear
    wr(3'd4, 8'd8);
    wr(3'd1, 8'h1f);
    pll_lock = 1'b1;
    beat_on = 1'b1;
    idle(12);
    check("R7 start flag", flags[1], 1);
    check("R10 irq on start", irq, 1);
    wr(3'd2, 8'h02);
    check("R9 start cleared", flags, 0);
    check("R10 irq cleared", irq, 0);
    wr(3'd2, 8'h00);
    check("R9 zero write", flags, 0);

    // R6 oscillator stop while in use
    wr(3'd0, 8'd3); wait_done();
    check("R2 on osc", sys_stat, 3);
    beat_on = 1'b0;
    idle(4);
    check("R13 no stop before timeout", flags[0], 0);
    idle(20);
    check("R6 stop flag", flags[0], 1);
    check("R6 fallback sel", sys_sel, 1);
    check("R6 fallback stat", sys_stat, 1);
    check("R10 irq on stop", irq, 1);
    // R7 restart returns to oscillator
    beat_on = 1'b1;
    idle(15);
    check("R7 start flag again", flags[1], 1);
    check("R7 return to osc", sys_stat, 3);
    // R10 enables gate irq
    wr(3'd1, 8'h03);
    check("R10 irq masked", irq, 0);
    wr(3'd2, 8'h07);
    check("R9 all cleared", flags, 0);

    // R8 PLL unlock
    wr(3'd0, 8'd5); wait_done();
    check("R8 on pll", sys_stat, 5);
    check("R8 pll_on_rc low", pll_on_rc, 0);
    pll_lock = 1'b0;
    idle(8);
    check("R8 unlock flag", flags[2], 1);
    check("R8 fallback", sys_stat, 1);
    check("R8 pll_on_rc", pll_on_rc, 1);
    wr(3'd0, 8'd4); wait_done();
    check("R8 pll_on_rc cleared", pll_on_rc, 0);

    // R6 oscillator stop while PLL runs, no return afterwards (R7)
    pll_lock = 1'b1;
    wr(3'd2, 8'h07);
    idle(6);
    wr(3'd0, 8'd5); wait_done();
    beat_on = 1'b0;
    idle(25);
    check("R6 fallback from pll", sys_stat, 1);
    beat_on = 1'b1;
    idle(15);
    check("R7 no return to osc", sys_stat, 1);

    // R12 monitors disabled
    wr(3'd1, 8'h1c);
    wr(3'd2, 8'h07);
    wr(3'd0, 8'd3); wait_done();
    beat_on = 1'b0;
    pll_lock = 1'b0;
    idle(30);
    check("R12 no flags", flags, 0);
    check("R12 stays on osc", sys_stat, 3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule